// File: doc/BRIEF.md
# PS/2 Mouse Packet Decoder

This block sits behind a PS/2 host-side serial receiver. It takes one received byte at a time through a valid strobe with 8-bit data and a per-byte parity-error flag. It groups the bytes into mouse movement packets, decodes the button states and the signed X, Y and wheel movement, and raises a single-cycle packet strobe when a packet is complete. The decoded values stay on the outputs until the next packet completes.

A static mode input selects the packet format. The plain three-button format has three bytes. The wheel format has four bytes. Packet alignment depends on a fixed marker bit in the header byte. A byte with a parity error throws away the partial packet. Each completed packet also adds its X and Y movement into two signed position counters. These counters clamp at their range limits instead of wrapping around.

Top module: `ps2m_packet_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, pktValid, the three button outputs, deltaX, deltaY, deltaWheel, posX and posY are all 0.
- R2: In the header slot, a valid byte with bit 3 equal to 0 is discarded. The decoder keeps waiting for a header. Only a byte with bit 3 set starts a packet.
- R3: From the header byte, bit 0 drives btnLeft, bit 1 drives btnRight and bit 2 drives btnMiddle. A 1 means pressed.
- R4: deltaX is the 9-bit two's-complement value {header bit 4, second byte}. deltaY is {header bit 5, third byte}.
- R5: With wheelMode = 0, a packet is header, X, Y. With wheelMode = 1, a fourth wheel byte follows. No packet strobe is raised before the last byte of the selected format.
- R6: In wheel mode, deltaWheel is the low nibble of the fourth byte, sign-extended to WHEEL_W bits. The high nibble of that byte has no effect. In three-byte mode, deltaWheel is 0.
- R7: pktValid is high for exactly the one cycle after the clock edge that accepts a packet's last byte. The decoded outputs change only at that edge and hold until the next one.
- R8: A valid byte flagged with a parity error abandons the packet in progress and raises no strobe for it. The next byte is treated as a candidate header.
- R9: On each packet, posX and posY, which are POS_W-bit two's complement values, are updated by adding deltaX and deltaY. Between packets they hold.
- R10: If an addition would go past the signed range, the position is clamped to the largest or smallest value (2047 / -2048 for POS_W = 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wheelMode | input | 1 | 0: three-byte packets, 1: four-byte packets with wheel |
| byteValid | input | 1 | A received byte is present this cycle |
| byteData | input | 8 | Received byte |
| byteParityErr | input | 1 | Received byte failed its parity check |
| pktValid | output | 1 | One-cycle strobe: a packet was decoded |
| btnLeft | output | 1 | Left button pressed |
| btnRight | output | 1 | Right button pressed |
| btnMiddle | output | 1 | Middle button pressed |
| deltaX | output | 9 | Signed X movement of the last packet |
| deltaY | output | 9 | Signed Y movement of the last packet |
| deltaWheel | output | WHEEL_W (8) | Signed wheel movement of the last packet |
| posX | output | POS_W (12) | Saturating accumulated X position |
| posY | output | POS_W (12) | Saturating accumulated Y position |

## Verification
The bench sends well-formed packets in both formats with random header bits and random movement bytes. This exposes any swapped button bit, wrong sign-bit source or wrong Y byte selection between the formats. Junk bytes with the marker bit clear are sent ahead of packets, and parity errors are injected on the header and on later bytes. These show whether alignment recovery and abort behave differently from a normal packet. Long runs of largest-magnitude positive and then negative movement drive both accumulators into their clamps. Wheel bytes with unrelated high nibbles show that only the low nibble counts.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam int BYTE_W       = 8;
  localparam int DELTA_W      = BYTE_W + 1;
  localparam int HDR_SYNC_BIT = 3;
  localparam int X_SIGN_BIT   = 4;
  localparam int Y_SIGN_BIT   = 5;
  localparam int WHEEL_FLD_W  = 4;

  typedef enum logic [1:0] {
    SLOT_HDR   = 2'd0,
    SLOT_X     = 2'd1,
    SLOT_Y     = 2'd2,
    SLOT_WHEEL = 2'd3
  } ps2mSlot_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capHdr;
    logic capX;
    logic capY;
    logic finish;
  } ps2mStrobe_t;
endpackage

// File: rtl/ps2m_ctrl.sv
module ps2m_ctrl
  import ps2m_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wheelMode,
  input  logic        byteValid,
  input  logic        hdrSync,
  input  logic        parityErr,
  output ps2mStrobe_t strobe
);
  ps2mSlot_e slot, nextSlot;

  always_comb begin
    strobe   = '0;
    nextSlot = slot;
    if (byteValid) begin
      if (parityErr) begin
        nextSlot = SLOT_HDR;
      end else begin
        case (slot)
          SLOT_HDR: begin
            if (hdrSync) begin
              strobe.capHdr = 1'b1;
              nextSlot      = SLOT_X;
            end
          end
          SLOT_X: begin
            strobe.capX = 1'b1;
            nextSlot    = SLOT_Y;
          end
          SLOT_Y: begin
            strobe.capY = 1'b1;
            if (wheelMode) begin
              nextSlot = SLOT_WHEEL;
            end else begin
              strobe.finish = 1'b1;
              nextSlot      = SLOT_HDR;
            end
          end
          SLOT_WHEEL: begin
            strobe.finish = 1'b1;
            nextSlot      = SLOT_HDR;
          end
          default: nextSlot = SLOT_HDR;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slot <= SLOT_HDR;
    else       slot <= nextSlot;
  end

  // R2: a header candidate without the marker bit leaves the decoder waiting
  p_resync_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !parityErr && slot == SLOT_HDR && !hdrSync |=> slot == SLOT_HDR);

  // R8: a parity error returns the decoder to the header slot
  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && parityErr |=> slot == SLOT_HDR);

  // R5: in three-byte mode the Y byte ends the packet
  p_short_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !parityErr && slot == SLOT_Y && !wheelMode |=> slot == SLOT_HDR);
endmodule

// File: rtl/ps2m_satacc.sv
module ps2m_satacc #(
  parameter int POS_W   = 12,
  parameter int DELTA_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               en,
  input  logic [DELTA_W-1:0] delta,
  output logic [POS_W-1:0]   pos
);
  localparam int SUM_W = POS_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = {1'b0, {(POS_W-1){1'b1}}};
  localparam logic [POS_W-1:0] POS_MIN = {1'b1, {(POS_W-1){1'b0}}};

  logic [SUM_W-1:0] sum;
  logic [POS_W-1:0] posNext;

  always_comb begin
    sum = {pos[POS_W-1], pos} + {{(SUM_W-DELTA_W){delta[DELTA_W-1]}}, delta};
    if (sum[SUM_W-1] != sum[SUM_W-2]) posNext = sum[SUM_W-1] ? POS_MIN : POS_MAX;
    else                              posNext = sum[POS_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   pos <= '0;
    else if (en) pos <= posNext;
  end

  // R9: position holds between packets
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(pos));

  // R10: clamped at the top, a non-negative step keeps it there
  p_sat_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    en && pos == POS_MAX && !delta[DELTA_W-1] |=> pos == POS_MAX);

  // R10: clamped at the bottom, a negative step keeps it there
  p_sat_lo_r10: assert property (@(posedge clk) disable iff (!rstN)
    en && pos == POS_MIN && delta[DELTA_W-1] |=> pos == POS_MIN);
endmodule

// File: rtl/ps2m_datapath.sv
module ps2m_datapath
  import ps2m_pkg::*;
#(
  parameter int POS_W   = 12,
  parameter int WHEEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ps2mStrobe_t        strobe,
  input  logic [BYTE_W-1:0]  byteData,
  output logic               pktValid,
  output logic [2:0]         buttons,
  output logic [DELTA_W-1:0] deltaX,
  output logic [DELTA_W-1:0] deltaY,
  output logic [WHEEL_W-1:0] deltaWheel,
  output logic [POS_W-1:0]   posX,
  output logic [POS_W-1:0]   posY
);
  logic [2:0]         btnQ;
  logic               xSignQ, ySignQ;
  logic [BYTE_W-1:0]  xQ, yQ;
  logic [BYTE_W-1:0]  yByte;
  logic [DELTA_W-1:0] dxNext, dyNext;
  logic [WHEEL_W-1:0] wheelNext;

  always_comb begin
    yByte     = strobe.capY ? byteData : yQ;
    dxNext    = {xSignQ, xQ};
    dyNext    = {ySignQ, yByte};
    wheelNext = strobe.capY ? '0
              : {{(WHEEL_W-WHEEL_FLD_W){byteData[WHEEL_FLD_W-1]}}, byteData[WHEEL_FLD_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnQ   <= '0;
      xSignQ <= 1'b0;
      ySignQ <= 1'b0;
      xQ     <= '0;
      yQ     <= '0;
    end else begin
      if (strobe.capHdr) begin
        btnQ   <= byteData[2:0];
        xSignQ <= byteData[X_SIGN_BIT];
        ySignQ <= byteData[Y_SIGN_BIT];
      end
      if (strobe.capX) xQ <= byteData;
      if (strobe.capY) yQ <= byteData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktValid   <= 1'b0;
      buttons    <= '0;
      deltaX     <= '0;
      deltaY     <= '0;
      deltaWheel <= '0;
    end else begin
      pktValid <= strobe.finish;
      if (strobe.finish) begin
        buttons    <= btnQ;
        deltaX     <= dxNext;
        deltaY     <= dyNext;
        deltaWheel <= wheelNext;
      end
    end
  end

  ps2m_satacc #(.POS_W(POS_W), .DELTA_W(DELTA_W)) accX_i (
    .clk(clk), .rstN(rstN), .en(strobe.finish), .delta(dxNext), .pos(posX));
  ps2m_satacc #(.POS_W(POS_W), .DELTA_W(DELTA_W)) accY_i (
    .clk(clk), .rstN(rstN), .en(strobe.finish), .delta(dyNext), .pos(posY));

  // R7: the packet strobe never lasts two cycles
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);

  // R7: decoded fields hold unless a packet completes
  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> $stable(buttons) && $stable(deltaX) && $stable(deltaY) && $stable(deltaWheel));
endmodule

// File: rtl/ps2m_packet_decoder.sv
module ps2m_packet_decoder
  import ps2m_pkg::*;
#(
  parameter int POS_W   = 12,
  parameter int WHEEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wheelMode,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               byteParityErr,
  output logic               pktValid,
  output logic               btnLeft,
  output logic               btnRight,
  output logic               btnMiddle,
  output logic [8:0]         deltaX,
  output logic [8:0]         deltaY,
  output logic [WHEEL_W-1:0] deltaWheel,
  output logic [POS_W-1:0]   posX,
  output logic [POS_W-1:0]   posY
);
  ps2mStrobe_t strobe;
  logic [2:0]  buttons;

  ps2m_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wheelMode(wheelMode), .byteValid(byteValid),
    .hdrSync(byteData[HDR_SYNC_BIT]), .parityErr(byteParityErr), .strobe(strobe));

  ps2m_datapath #(.POS_W(POS_W), .WHEEL_W(WHEEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .pktValid(pktValid), .buttons(buttons), .deltaX(deltaX), .deltaY(deltaY),
    .deltaWheel(deltaWheel), .posX(posX), .posY(posY));

  assign btnLeft   = buttons[0];
  assign btnRight  = buttons[1];
  assign btnMiddle = buttons[2];
endmodule

// File: tb/ps2m_packet_decoder_tb.sv
module ps2m_packet_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W      = 12;
  localparam int WHEEL_W    = 8;
  localparam int POS_MAXV   = 2047;
  localparam int POS_MINV   = -2048;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wheelMode = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteParityErr = 1'b0;
  logic pktValid, btnLeft, btnRight, btnMiddle;
  logic [8:0] deltaX, deltaY;
  logic [WHEEL_W-1:0] deltaWheel;
  logic [POS_W-1:0] posX, posY;

  int checks = 0;
  int errors = 0;
  int expX = 0;
  int expY = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2m_packet_decoder #(.POS_W(POS_W), .WHEEL_W(WHEEL_W)) dut_i (
    .clk(clk), .rstN(rstN), .wheelMode(wheelMode), .byteValid(byteValid),
    .byteData(byteData), .byteParityErr(byteParityErr), .pktValid(pktValid),
    .btnLeft(btnLeft), .btnRight(btnRight), .btnMiddle(btnMiddle),
    .deltaX(deltaX), .deltaY(deltaY), .deltaWheel(deltaWheel), .posX(posX), .posY(posY));

  function automatic int satAdd(input int p, input int d);
    int s = p + d;
    if (s > POS_MAXV) return POS_MAXV;
    if (s < POS_MINV) return POS_MINV;
    return s;
  endfunction

  function automatic int ext9(input bit s, input logic [7:0] b);
    return s ? int'(b) - 256 : int'(b);
  endfunction

  function automatic int wheelVal(input logic [7:0] b);
    return b[3] ? int'(b[3:0]) - 16 : int'(b[3:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one byte for one cycle; returns pktValid seen after the accepting edge
  task automatic sendByte(input logic [7:0] d, input bit err, output bit v);
    @(negedge clk);
    byteValid = 1'b1; byteData = d; byteParityErr = err;
    @(negedge clk);
    byteValid = 1'b0; byteParityErr = 1'b0;
    v = pktValid;
  endtask

  task automatic sendPacket(input logic [7:0] hdr, input logic [7:0] x,
                            input logic [7:0] y, input logic [7:0] w);
    bit v;
    int dx, dy, ew;
    bit clampX, clampY;
    sendByte(hdr, 1'b0, v); chk(!v, "R5 early strobe after header", v, 0);
    sendByte(x, 1'b0, v);   chk(!v, "R5 early strobe after X", v, 0);
    if (wheelMode) begin
      sendByte(y, 1'b0, v); chk(!v, "R5 early strobe after Y in wheel mode", v, 0);
      sendByte(w, 1'b0, v);
      ew = wheelVal(w);
    end else begin
      sendByte(y, 1'b0, v);
      ew = 0;
    end
    chk(v, "R7 strobe after last byte", v, 1);
    dx = ext9(hdr[4], x);
    dy = ext9(hdr[5], y);
    clampX = (expX + dx > POS_MAXV) || (expX + dx < POS_MINV);
    clampY = (expY + dy > POS_MAXV) || (expY + dy < POS_MINV);
    expX = satAdd(expX, dx);
    expY = satAdd(expY, dy);
    chk({btnMiddle, btnRight, btnLeft} == hdr[2:0], "R3 buttons",
        int'({btnMiddle, btnRight, btnLeft}), int'(hdr[2:0]));
    chk(int'($signed(deltaX)) == dx, "R4 deltaX", int'($signed(deltaX)), dx);
    chk(int'($signed(deltaY)) == dy, "R4 deltaY", int'($signed(deltaY)), dy);
    chk(int'($signed(deltaWheel)) == ew, "R6 wheel", int'($signed(deltaWheel)), ew);
    chk(int'($signed(posX)) == expX, clampX ? "R10 posX clamp" : "R9 posX",
        int'($signed(posX)), expX);
    chk(int'($signed(posY)) == expY, clampY ? "R10 posY clamp" : "R9 posY",
        int'($signed(posY)), expY);
    @(negedge clk);
    chk(!pktValid, "R7 strobe one cycle", pktValid, 0);
    chk(int'($signed(posX)) == expX, "R7 posX held", int'($signed(posX)), expX);
  endtask

  task automatic noStrobe(input logic [7:0] d, input bit err, input string req);
    bit v;
    sendByte(d, err, v);
    chk(!v, req, v, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!pktValid && posX == 0 && deltaX == 0, "R1 in reset", int'(posX), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!pktValid, "R1 strobe low", pktValid, 0);
    chk({btnLeft, btnRight, btnMiddle} == 0, "R1 buttons", int'({btnLeft, btnRight, btnMiddle}), 0);
    chk(deltaX == 0 && deltaY == 0 && deltaWheel == 0, "R1 deltas",
        int'(deltaX) + int'(deltaY) + int'(deltaWheel), 0);
    chk(posX == 0 && posY == 0, "R1 positions", int'(posX) + int'(posY), 0);

    // directed, three-byte mode
    wheelMode = 1'b0;
    sendPacket(8'h09, 8'd5, 8'd3, 8'h00);
    sendPacket(8'h3A, 8'hF0, 8'h80, 8'h00);

    // wheel mode: negative nibble, then high nibble unrelated
    wheelMode = 1'b1;
    sendPacket(8'h0E, 8'd1, 8'd2, 8'hFF);
    sendPacket(8'h0C, 8'd0, 8'd0, 8'hA7);
    sendPacket(8'h08, 8'd0, 8'd0, 8'h58);

    // R2: junk bytes without marker bit are dropped
    wheelMode = 1'b0;
    noStrobe(8'h00, 1'b0, "R2 junk byte dropped");
    noStrobe(8'hF7, 1'b0, "R2 junk byte dropped");
    noStrobe(8'h37, 1'b0, "R2 junk byte dropped");
    sendPacket(8'h0B, 8'd7, 8'd9, 8'h00);

    // R8: parity error on a later byte and on the header
    noStrobe(8'h09, 1'b0, "R8 partial header");
    noStrobe(8'h11, 1'b0, "R8 partial X");
    noStrobe(8'h22, 1'b1, "R8 errored byte");
    sendPacket(8'h0A, 8'd4, 8'd4, 8'h00);
    noStrobe(8'h0F, 1'b1, "R8 errored header");
    noStrobe(8'h05, 1'b0, "R8 byte after errored header is not header");
    sendPacket(8'h08, 8'd1, 8'd1, 8'h00);
    wheelMode = 1'b1;
    noStrobe(8'h08, 1'b0, "R8 wheel partial header");
    noStrobe(8'h01, 1'b0, "R8 wheel partial X");
    noStrobe(8'h02, 1'b0, "R8 wheel partial Y");
    noStrobe(8'h03, 1'b1, "R8 errored wheel byte");
    sendPacket(8'h08, 8'd2, 8'd2, 8'h01);

    // R10: drive both axes into the clamps
    wheelMode = 1'b0;
    for (int i = 0; i < 12; i++) sendPacket(8'h08, 8'hFF, 8'hFF, 8'h00);
    chk(int'($signed(posX)) == POS_MAXV, "R10 top clamp X", int'($signed(posX)), POS_MAXV);
    for (int i = 0; i < 20; i++) sendPacket(8'h38, 8'h00, 8'h00, 8'h00);
    chk(int'($signed(posY)) == POS_MINV, "R10 bottom clamp Y", int'($signed(posY)), POS_MINV);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] hdr;
      wheelMode = ($urandom % 2) != 0;
      if ($urandom % 4 == 0) noStrobe(8'($urandom) & 8'hF7, 1'b0, "R2 random junk");
      if ($urandom % 5 == 0) begin
        noStrobe(8'($urandom) | 8'h08, 1'b0, "R8 random partial header");
        if ($urandom % 2 != 0) noStrobe(8'($urandom), 1'b0, "R8 random partial X");
        noStrobe(8'($urandom), 1'b1, "R8 random errored byte");
      end
      hdr = 8'($urandom) | 8'h08;
      sendPacket(hdr, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule